// File: doc/BRIEF.md
# Embedded-Clock Serial Frame Locker

This block sits behind a bit-clock recovery stage and takes a serial stream that carries its own framing. The stream arrives one bit per assertion of a bit enable. Each frame is twelve bits long: one high start bit, ten data bits, and one low stop bit. The low stop bit of one frame is always followed directly by the high start bit of the next. That low-to-high step repeats every twelve bits, and it is the only marker the receiver has for finding word boundaries.

The locker tests one twelve-bit alignment at a time. When a candidate window does not have a high first bit and a low last bit, the locker moves on by one bit position and tests again. Once the same alignment has passed several consecutive frames, the locker declares lock. From then on it delivers the ten data bits of every well-formed frame as a parallel word, together with a single-cycle valid pulse. The lock indication is active low. It is meant to be wired back to the transmitter, which sends its slow square-wave sync pattern until this line goes low and then switches to live data. The locker also acquires random data with no sync pattern, though the time to lock then varies. If framing is lost, the locker releases lock and starts searching again.

Top module: `embclk_frame_locker`

## Requirements
- R1: A frame window is twelve sampled bits. It is well formed when its first bit is 1 and its twelfth bit is 0. The i-th data bit after the start bit (i = 0..9) appears on `wordOut[i]`, so the first data bit on the wire is the least significant bit.
- R2: Only cycles with `bitEn` high take a bit from `serIn`. In all other cycles, `serIn` has no effect on `lockN` or on the words delivered.
- R3: After reset, and whenever the block is not locked, `lockN` is 1, `wordOut` is all zeros and `wordValid` is 0.
- R4: Lock is declared after four consecutive well-formed frames at the same alignment. `lockN` is 0 in the cycle after the stop bit of the fourth frame is sampled, and that fourth frame produces no word.
- R5: When a candidate window is not well formed during the search, the next window tested ends one bit later. As a result, a stream that begins at an arbitrary bit offset, or after idle zeros, is aligned correctly.
- R6: A stream of frames with random data bits leads to lock. The alignment then agrees with the true frame boundary, so later frames are delivered with their correct data.
- R7: While locked, each well-formed frame produces exactly one word. `wordValid` is high for one cycle, in the cycle after the stop bit is sampled, with the frame's data on `wordOut`.
- R8: While locked, a single frame that is not well formed produces no word and keeps lock. The next well-formed frame is delivered normally.
- R9: While locked, two consecutive frames that are not well formed drive `lockN` to 1 in the cycle after the second frame's stop bit. They also clear `wordOut` and restart the search. Lock then returns after four further well-formed frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | High for one cycle per recovered bit time |
| serIn | input | 1 | Serial stream, sampled when `bitEn` is high |
| lockN | output | 1 | Active-low lock indication, fed back to the transmitter |
| wordOut | output | DATA_W (10) | Recovered data word, LSB first on the wire |
| wordValid | output | 1 | One-cycle strobe marking a new word |

## Verification
The bench builds the block with its default parameters: ten data bits, four frames to lock and two bad frames to drop. With these values, every lock and drop moment falls on a frame the bench can name in advance. The bit enable is driven with irregular gaps of zero to two idle cycles, and `serIn` is driven to the wrong value during those gaps. This makes any sampling outside `bitEn` visible in the delivered words. A leading run of idle zeros forces the bit-slip search, and a zero-filled bad pair makes the point of relock exact. A long random-data phase exercises acquisition when false boundaries are present.

// File: rtl/efl_pkg.sv
package efl_pkg;

  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic slip;   // hold the window counter so the next window ends one bit later
    logic load;   // capture the current data bits as an output word
    logic clear;  // zero the output word
  } ctrlStrobe_t;

  typedef enum logic [0:0] {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } lockState_t;

endpackage

// File: rtl/efl_datapath.sv
module efl_datapath
  import efl_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              serIn,
  input  ctrlStrobe_t       ctrl,
  output logic              frameEnd,
  output logic              frameGood,
  output logic [DATA_W-1:0] wordOut,
  output logic              wordValid
);

  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-2:0] histReg;   // the previous FRAME_W-1 sampled bits, newest at bit 0
  logic [FRAME_W-1:0] window;    // window ending with the bit being sampled now
  logic [CNT_W-1:0]   bitCnt;
  logic [DATA_W-1:0]  dataBits;

  assign window = {histReg, serIn};

  // Bit history: shifts only on a bit time (R2)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histReg <= '0;
    end else if (bitEn) begin
      histReg <= window[FRAME_W-2:0];
    end
  end

  // Window position counter; a slip repeats the last position (R5)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (bitEn) begin
      if (bitCnt == LAST_POS) begin
        bitCnt <= ctrl.slip ? bitCnt : '0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign frameEnd  = bitEn && (bitCnt == LAST_POS);
  // Oldest bit is the start bit, newest is the stop bit (R1)
  assign frameGood = window[FRAME_W-1] && !window[0];

  // LSB-first reassembly: data bit i sits i+1 positions after the start (R1)
  for (genvar i = 0; i < DATA_W; i++) begin : g_unpack
    assign dataBits[i] = window[FRAME_W-2-i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= ctrl.load;
      if (ctrl.clear) begin
        wordOut <= '0;
      end else if (ctrl.load) begin
        wordOut <= dataBits;
      end
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  a_r2_count_range: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_POS);

  a_r2_hold_without_enable: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(bitCnt) && $stable(histReg));

endmodule

// File: rtl/efl_control.sv
module efl_control
  import efl_pkg::*;
#(
  parameter int LOCK_FRAMES = 4,
  parameter int DROP_FRAMES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameEnd,
  input  logic        frameGood,
  output ctrlStrobe_t ctrl,
  output logic        lockN
);

  localparam int GOOD_W = $clog2(LOCK_FRAMES + 1);
  localparam int BAD_W  = $clog2(DROP_FRAMES + 1);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_FRAMES - 1);
  localparam logic [BAD_W-1:0]  BAD_LAST  = BAD_W'(DROP_FRAMES - 1);

  lockState_t        state, stateNext;
  logic [GOOD_W-1:0] goodCnt, goodNext;
  logic [BAD_W-1:0]  badCnt, badNext;

  always_comb begin
    stateNext  = state;
    goodNext   = goodCnt;
    badNext    = badCnt;
    ctrl       = '0;
    if (frameEnd) begin
      unique case (state)
        ST_SEARCH: begin
          if (frameGood) begin
            if (goodCnt == GOOD_LAST) begin      // R4
              stateNext = ST_LOCKED;
              goodNext  = '0;
              badNext   = '0;
            end else begin
              goodNext = goodCnt + 1'b1;
            end
          end else begin                         // R5
            goodNext  = '0;
            ctrl.slip = 1'b1;
          end
        end
        ST_LOCKED: begin
          if (frameGood) begin                   // R7
            ctrl.load = 1'b1;
            badNext   = '0;
          end else if (badCnt == BAD_LAST) begin // R9
            stateNext  = ST_SEARCH;
            goodNext   = '0;
            badNext    = '0;
            ctrl.clear = 1'b1;
            ctrl.slip  = 1'b1;
          end else begin                         // R8
            badNext = badCnt + 1'b1;
          end
        end
        default: stateNext = ST_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_SEARCH;
      goodCnt <= '0;
      badCnt  <= '0;
    end else begin
      state   <= stateNext;
      goodCnt <= goodNext;
      badCnt  <= badNext;
    end
  end

  assign lockN = (state != ST_LOCKED);

  a_r4_lock_after_good: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockN) |-> $past(frameEnd && frameGood));

  a_r9_drop_after_bad: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockN) |-> $past(frameEnd && !frameGood));

  a_r5_slip_only_on_bad: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.slip |-> frameEnd && !frameGood);

endmodule

// File: rtl/embclk_frame_locker.sv
module embclk_frame_locker
  import efl_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int LOCK_FRAMES = 4,
  parameter int DROP_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              serIn,
  output logic              lockN,
  output logic [DATA_W-1:0] wordOut,
  output logic              wordValid
);

  ctrlStrobe_t ctrl;
  logic        frameEnd;
  logic        frameGood;

  efl_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .bitEn     (bitEn),
    .serIn     (serIn),
    .ctrl      (ctrl),
    .frameEnd  (frameEnd),
    .frameGood (frameGood),
    .wordOut   (wordOut),
    .wordValid (wordValid)
  );

  efl_control #(
    .LOCK_FRAMES (LOCK_FRAMES),
    .DROP_FRAMES (DROP_FRAMES)
  ) i_control (
    .clk       (clk),
    .rstN      (rstN),
    .frameEnd  (frameEnd),
    .frameGood (frameGood),
    .ctrl      (ctrl),
    .lockN     (lockN)
  );

  a_r3_quiet_unlocked: assert property (@(posedge clk) disable iff (!rstN)
    lockN |-> (wordOut == '0) && !wordValid);

  a_r7_word_only_locked: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> !lockN);

endmodule

// File: tb/test_embclk_frame_locker.sv
module test_embclk_frame_locker;

  localparam int DATA_W = 10;
  localparam logic [DATA_W-1:0] SYNC_WORD = 10'h01F; // five ones then five zeros, LSB first

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              bitEn = 1'b0;
  logic              serIn = 1'b0;
  logic              lockN;
  logic [DATA_W-1:0] wordOut;
  logic              wordValid;

  int testsRun = 0;
  int testsFailed = 0;
  int gapSel = 0;
  bit armed = 1'b1;
  bit finished = 1'b0;
  logic [DATA_W-1:0] expQ[$];

  always #2 clk = ~clk;

  embclk_frame_locker #(.DATA_W(DATA_W)) i_embclk_frame_locker (
    .clk       (clk),
    .rstN      (rstN),
    .bitEn     (bitEn),
    .serIn     (serIn),
    .lockN     (lockN),
    .wordOut   (wordOut),
    .wordValid (wordValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // One bit time; idle cycles carry the opposite value to show they are ignored (R2)
  task automatic sendBit(input logic b);
    @(negedge clk);
    bitEn = 1'b1;
    serIn = b;
    @(negedge clk);
    bitEn = 1'b0;
    serIn = ~b;
    for (int k = 0; k < gapSel; k++) @(negedge clk);
    gapSel = (gapSel + 1) % 3;
  endtask

  task automatic sendFrame(input logic startB, input logic [DATA_W-1:0] d,
                           input logic stopB, input bit expectWord);
    if (expectWord) expQ.push_back(d);
    sendBit(startB);
    for (int i = 0; i < DATA_W; i++) sendBit(d[i]);
    sendBit(stopB);
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN) begin
        if (lockN) begin
          check((wordOut == '0) && !wordValid, "R3 unlocked quiet",
                int'({wordValid, wordOut}), 0);
        end
        if (wordValid && armed) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R7 unexpected word", int'(wordOut), -1);
          end else begin
            logic [DATA_W-1:0] e;
            e = expQ.pop_front();
            check(wordOut == e, "R1/R7 word value", int'(wordOut), int'(e));
          end
        end
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(lockN && (wordOut == '0) && !wordValid, "R3 in reset", int'(lockN), 1);
    rstN = 1'b1;
    @(negedge clk);
    check(lockN == 1'b1, "R3 after reset", int'(lockN), 1);

    // R5: idle zeros put the first window off the boundary
    for (int i = 0; i < 5; i++) sendBit(1'b0);

    // R4: three sync frames are not enough, the fourth locks
    for (int f = 0; f < 3; f++) sendFrame(1'b1, SYNC_WORD, 1'b0, 1'b0);
    check(lockN == 1'b1, "R4 no lock after three", int'(lockN), 1);
    sendFrame(1'b1, SYNC_WORD, 1'b0, 1'b0);
    check(lockN == 1'b0, "R4 lock after four", int'(lockN), 0);

    // R7/R1: words with assorted patterns
    sendFrame(1'b1, SYNC_WORD, 1'b0, 1'b1);
    sendFrame(1'b1, 10'h001, 1'b0, 1'b1);
    sendFrame(1'b1, 10'h200, 1'b0, 1'b1);
    sendFrame(1'b1, 10'h3FF, 1'b0, 1'b1);
    sendFrame(1'b1, 10'h000, 1'b0, 1'b1);
    sendFrame(1'b1, 10'h155, 1'b0, 1'b1);
    for (int f = 0; f < 6; f++) sendFrame(1'b1, DATA_W'($urandom), 1'b0, 1'b1);

    // R8: one bad stop bit keeps lock and emits nothing
    sendFrame(1'b1, 10'h2A5, 1'b1, 1'b0);
    check(lockN == 1'b0, "R8 lock kept", int'(lockN), 0);
    sendFrame(1'b1, 10'h0F0, 1'b0, 1'b1);
    sendFrame(1'b0, 10'h000, 1'b0, 1'b0);
    check(lockN == 1'b0, "R8 lock kept after bad start", int'(lockN), 0);
    sendFrame(1'b1, 10'h30C, 1'b0, 1'b1);

    // R9: two bad frames drop lock, four good frames relock
    sendFrame(1'b0, 10'h000, 1'b0, 1'b0);
    check(lockN == 1'b0, "R9 still locked after one", int'(lockN), 0);
    sendFrame(1'b0, 10'h000, 1'b0, 1'b0);
    check(lockN == 1'b1, "R9 dropped after two", int'(lockN), 1);
    check(wordOut == '0, "R9 word cleared", int'(wordOut), 0);
    for (int f = 0; f < 3; f++) sendFrame(1'b1, SYNC_WORD, 1'b0, 1'b0);
    check(lockN == 1'b1, "R9 searching after three", int'(lockN), 1);
    sendFrame(1'b1, SYNC_WORD, 1'b0, 1'b0);
    check(lockN == 1'b0, "R9 relocked after four", int'(lockN), 0);
    sendFrame(1'b1, 10'h1C3, 1'b0, 1'b1);

    // R6: random data acquisition from reset, no sync pattern
    rstN = 1'b0;
    armed = 1'b0;
    @(negedge clk);
    check(lockN == 1'b1, "R3 reset while locked", int'(lockN), 1);
    rstN = 1'b1;
    for (int i = 0; i < 7; i++) sendBit(1'b1);
    for (int f = 0; f < 40; f++) sendFrame(1'b1, DATA_W'($urandom), 1'b0, 1'b0);
    check(lockN == 1'b0, "R6 locked on random data", int'(lockN), 0);
    for (int f = 0; f < 8; f++) sendFrame(1'b1, SYNC_WORD, 1'b0, 1'b0);
    check(lockN == 1'b0, "R6 lock held", int'(lockN), 0);
    armed = 1'b1;
    for (int f = 0; f < 5; f++) sendFrame(1'b1, DATA_W'($urandom), 1'b0, 1'b1);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R7 all words delivered", expQ.size(), 0);
    finish();
  end

endmodule